// File: doc/BRIEF.md
# Bus Error Status Logging Register

This block keeps a 64-bit record of external bus and memory errors. The bus interface sends it single-cycle event pulses. There are four kinds of event: an internal fatal error, a failed address-parity check on a transaction this component started, a corrected ECC event and an uncorrected ECC event. Each ECC event comes with an 8-bit syndrome. The register holds a sticky flag for each kind of error, the captured syndrome, a 16-bit compound error code and a valid indicator. Each field has its own rule for when a new value may be captured and when the old value must be kept.

Software reads the full register on `status` at all times. It clears bits by driving `clr_en` together with a mask. Each bit that is set in the mask goes to zero at the next clock edge, unless a rule below keeps it. The block does not compute ECC, detect parity or raise interrupts.

Top module: `bus_err_status_log`

## Requirements
- R1: After reset, and after any later reset, all 64 bits of `status` read zero.
- R2: An `int_err_evt` pulse sets bit 43 at the next edge. The bit then stays set until software clears it.
- R3: Bit 44 sets on the second failing address-parity transaction counted since reset or since the last software clear of bit 44. A single failure does not set it.
- R4: A software clear of bit 44 resets the failure count. After the clear, two new failures are needed before bit 44 sets again.
- R5: A `ecc_unc_evt` pulse sets bit 45. A `ecc_corr_evt` pulse sets bit 46. Both bits are sticky.
- R6: Bits 54:47 load `ecc_syn` on either ECC event, but only when bit 45 was clear beforehand. While bit 45 stays set, neither a new ECC event nor a software clear changes these bits.
- R7: If an ECC event arrives in the same cycle that software clears bit 45, the new syndrome is captured.
- R8: If a hardware set and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: Bits 15:0 load the code {4'b0000, 1'b1, pp[1:0], t, rrrr[3:0], ii[1:0], ll[1:0]} on any event, but only when bit 63 is clear or is being cleared in that cycle. Otherwise they keep the first code. Software can clear them bit by bit.
- R10: Bit 63 is the valid indicator. Any event pulse sets it, and software clears it.
- R11: Bits 42:16 and 62:55 always read zero. Clearing them has no effect on any other bit.
- R12: With `clr_en` high, each masked bit that has no same-cycle capture or set reads zero after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_err_evt | input | 1 | Internal fatal error pulse |
| apar_fail_evt | input | 1 | Own transaction failed address parity, pulse |
| ecc_corr_evt | input | 1 | Corrected ECC event pulse |
| ecc_unc_evt | input | 1 | Uncorrected ECC event pulse |
| ecc_syn | input | 8 | Syndrome that goes with an ECC pulse |
| code_pp | input | 2 | Participation field of the error code |
| code_t | input | 1 | Timeout field of the error code |
| code_rrrr | input | 4 | Request type field of the error code |
| code_ii | input | 2 | Transaction type field of the error code |
| code_ll | input | 2 | Level field of the error code |
| clr_en | input | 1 | Software clear strobe |
| clr_mask | input | 64 | Bits to clear when `clr_en` is high |
| status | output | 64 | Logged status word |

## Verification
The assertions assume that every event input and `clr_en` is a known, synchronous level sampled at the rising edge. They also assume that `ecc_syn` and the code fields are valid in any cycle that carries a relevant event. No handshake is involved, because each pulse is taken as a complete event. The stimulus changes every input only on the falling edge and holds each vector for exactly one cycle, so every pulse is one cycle long. Syndrome and code values change only together with the pulse they belong to.

// File: rtl/bes_pkg.sv
package bes_pkg;
  localparam int unsigned REG_W      = 64;
  localparam int unsigned SYN_W      = 8;
  localparam int unsigned CODE_W     = 16;
  localparam int unsigned APAR_LIMIT = 2;

  // bit positions read by software
  localparam int unsigned IERR_BIT  = 43;
  localparam int unsigned APAR_BIT  = 44;
  localparam int unsigned UNC_BIT   = 45;
  localparam int unsigned CORR_BIT  = 46;
  localparam int unsigned SYN_LSB   = 47;
  localparam int unsigned VALID_BIT = 63;

  // simple sticky flags handled by the generic flag cell
  localparam int unsigned NFLAG = 4;
  localparam int unsigned FL_IERR  = 0;
  localparam int unsigned FL_UNC   = 1;
  localparam int unsigned FL_CORR  = 2;
  localparam int unsigned FL_VALID = 3;

  typedef struct packed {
    logic [1:0] pp;
    logic       t;
    logic [3:0] rrrr;
    logic [1:0] ii;
    logic [1:0] ll;
  } err_code_t;

  function automatic int unsigned flag_pos(input int unsigned idx);
    case (idx)
      FL_IERR: return IERR_BIT;
      FL_UNC:  return UNC_BIT;
      FL_CORR: return CORR_BIT;
      default: return VALID_BIT;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] build_code(input err_code_t c);
    return {4'b0000, 1'b1, c};
  endfunction
endpackage

// File: rtl/bes_sticky_flag.sv
module bes_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
endmodule

// File: rtl/bes_apar_tracker.sv
module bes_apar_tracker #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic clr,
  output logic flag
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] NEAR = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (fail && cnt == NEAR)
      cnt <= TOP;                       // the set beats a same-cycle clear
    else if (clr)
      cnt <= fail ? CNT_W'(1) : '0;
    else if (fail && cnt < TOP)
      cnt <= cnt + CNT_W'(1);
  end

  assign flag = (cnt == TOP);

  // R3
  apar_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && cnt == NEAR) |=> flag);
  // R3
  apar_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(fail));
  // R4
  apar_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fail) |=> (cnt == '0 && !flag));
endmodule

// File: rtl/bes_field_reg.sv
module bes_field_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] din,
  input  logic         protect,
  input  logic         clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)               q <= '0;
    else if (cap)             q <= din;
    else if (clr && !protect) q <= q & ~mask;
  end

  // R6
  field_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (q == $past(din)));
  // R6
  field_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (protect && !cap) |=> $stable(q));
endmodule

// File: rtl/bus_err_status_log.sv
module bus_err_status_log
  import bes_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_err_evt,
  input  logic              apar_fail_evt,
  input  logic              ecc_corr_evt,
  input  logic              ecc_unc_evt,
  input  logic [SYN_W-1:0]  ecc_syn,
  input  logic [1:0]        code_pp,
  input  logic              code_t,
  input  logic [3:0]        code_rrrr,
  input  logic [1:0]        code_ii,
  input  logic [1:0]        code_ll,
  input  logic              clr_en,
  input  logic [REG_W-1:0]  clr_mask,
  output logic [REG_W-1:0]  status
);
  logic [NFLAG-1:0]  flag_set;
  logic [NFLAG-1:0]  flag_clr;
  logic [NFLAG-1:0]  flag_q;
  logic              apar_flag;
  logic [SYN_W-1:0]  syn_q;
  logic [CODE_W-1:0] code_q;
  logic              any_evt;
  logic              ecc_evt;
  logic              unc_lock;
  logic              syn_cap;
  logic              code_cap;
  logic              clr_valid;
  logic              clr_unc;
  err_code_t         code_in;

  assign any_evt   = int_err_evt | apar_fail_evt | ecc_corr_evt | ecc_unc_evt;
  assign ecc_evt   = ecc_corr_evt | ecc_unc_evt;
  assign clr_valid = clr_en & clr_mask[VALID_BIT];
  assign clr_unc   = clr_en & clr_mask[UNC_BIT];

  assign flag_set[FL_IERR]  = int_err_evt;
  assign flag_set[FL_UNC]   = ecc_unc_evt;
  assign flag_set[FL_CORR]  = ecc_corr_evt;
  assign flag_set[FL_VALID] = any_evt;

  genvar g;
  generate
    for (g = 0; g < NFLAG; g++) begin : g_flag
      assign flag_clr[g] = clr_en & clr_mask[flag_pos(g)];
      bes_sticky_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set[g]),
        .clr   (flag_clr[g]),
        .q     (flag_q[g])
      );
    end
  endgenerate

  bes_apar_tracker #(.LIMIT(APAR_LIMIT)) u_apar (
    .clk   (clk),
    .rst_n (rst_n),
    .fail  (apar_fail_evt),
    .clr   (clr_en & clr_mask[APAR_BIT]),
    .flag  (apar_flag)
  );

  // the syndrome stays locked while an uncorrected error is logged and not being cleared
  assign unc_lock = flag_q[FL_UNC] & ~clr_unc;
  assign syn_cap  = ecc_evt & ~unc_lock;

  bes_field_reg #(.W(SYN_W)) u_syn (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (syn_cap),
    .din     (ecc_syn),
    .protect (unc_lock),
    .clr     (clr_en),
    .mask    (clr_mask[SYN_LSB +: SYN_W]),
    .q       (syn_q)
  );

  assign code_in  = '{pp: code_pp, t: code_t, rrrr: code_rrrr, ii: code_ii, ll: code_ll};
  assign code_cap = any_evt & (~flag_q[FL_VALID] | clr_valid);

  bes_field_reg #(.W(CODE_W)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (code_cap),
    .din     (build_code(code_in)),
    .protect (1'b0),
    .clr     (clr_en),
    .mask    (clr_mask[CODE_W-1:0]),
    .q       (code_q)
  );

  always_comb begin
    status                     = '0;
    status[CODE_W-1:0]         = code_q;
    status[IERR_BIT]           = flag_q[FL_IERR];
    status[APAR_BIT]           = apar_flag;
    status[UNC_BIT]            = flag_q[FL_UNC];
    status[CORR_BIT]           = flag_q[FL_CORR];
    status[SYN_LSB +: SYN_W]   = syn_q;
    status[VALID_BIT]          = flag_q[FL_VALID];
  end

  logic unused_rsvd_mask;
  assign unused_rsvd_mask = ^{clr_mask[42:16], clr_mask[62:55]};

  // R10
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> status[VALID_BIT]);
  // R9
  code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[VALID_BIT] && !clr_valid && !(clr_en && |clr_mask[CODE_W-1:0]))
      |=> $stable(status[CODE_W-1:0]));
  // R7
  syn_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_evt && clr_unc) |=> (status[SYN_LSB +: SYN_W] == $past(ecc_syn)));
  // R5
  unc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_unc_evt |=> status[UNC_BIT]);
endmodule

// File: tb/test_bus_err_status_log.sv
module test_bus_err_status_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_err_evt = 1'b0, apar_fail_evt = 1'b0;
  logic        ecc_corr_evt = 1'b0, ecc_unc_evt = 1'b0;
  logic [7:0]  ecc_syn = '0;
  logic [1:0]  code_pp = '0, code_ii = '0, code_ll = '0;
  logic        code_t = 1'b0;
  logic [3:0]  code_rrrr = '0;
  logic        clr_en = 1'b0;
  logic [63:0] clr_mask = '0;
  logic [63:0] status;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bus_err_status_log i_bus_err_status_log (
    .clk(clk), .rst_n(rst_n), .int_err_evt(int_err_evt), .apar_fail_evt(apar_fail_evt),
    .ecc_corr_evt(ecc_corr_evt), .ecc_unc_evt(ecc_unc_evt), .ecc_syn(ecc_syn),
    .code_pp(code_pp), .code_t(code_t), .code_rrrr(code_rrrr), .code_ii(code_ii),
    .code_ll(code_ll), .clr_en(clr_en), .clr_mask(clr_mask), .status(status)
  );

  localparam logic [63:0] F_IERR = 64'd1 << 43;
  localparam logic [63:0] F_APAR = 64'd1 << 44;
  localparam logic [63:0] F_UNC  = 64'd1 << 45;
  localparam logic [63:0] F_CORR = 64'd1 << 46;
  localparam logic [63:0] F_VAL  = 64'd1 << 63;
  localparam logic [63:0] M_SYN  = {9'b0, 8'hFF, 47'b0};
  localparam logic [63:0] M_RSV  = {1'b0, 8'hFF, 8'h00, 4'h0, 27'h7FF_FFFF, 16'h0000};
  localparam logic [63:0] M_ALL  = '1;

  function automatic logic [63:0] syn_f(input logic [7:0] s);
    return {9'b0, s, 47'b0};
  endfunction
  function automatic logic [63:0] code_f(input logic [10:0] c);
    return {48'b0, 4'b0000, 1'b1, c};
  endfunction

  // ev = {unc, corr, apar, ierr}
  typedef struct packed {
    logic [3:0]  ev;
    logic [7:0]  syn;
    logic [10:0] code;
    logic        clr;
    logic [63:0] mask;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'b0001, 8'h00, 11'h123, 1'b0, 64'h0, F_IERR|F_VAL|code_f(11'h123)},
    '{4'b0010, 8'h00, 11'h055, 1'b0, 64'h0, F_IERR|F_VAL|code_f(11'h123)},
    '{4'b0010, 8'h00, 11'h0AA, 1'b0, 64'h0, F_IERR|F_APAR|F_VAL|code_f(11'h123)},
    '{4'b0100, 8'h5A, 11'h000, 1'b0, 64'h0, F_IERR|F_APAR|F_CORR|syn_f(8'h5A)|F_VAL|code_f(11'h123)},
    '{4'b1000, 8'h3C, 11'h000, 1'b0, 64'h0, F_IERR|F_APAR|F_UNC|F_CORR|syn_f(8'h3C)|F_VAL|code_f(11'h123)},
    '{4'b0100, 8'h77, 11'h000, 1'b0, 64'h0, F_IERR|F_APAR|F_UNC|F_CORR|syn_f(8'h3C)|F_VAL|code_f(11'h123)},
    '{4'b0000, 8'h00, 11'h000, 1'b1, M_ALL, 64'h0},
    '{4'b0010, 8'h00, 11'h011, 1'b0, 64'h0, F_VAL|code_f(11'h011)},
    '{4'b0010, 8'h00, 11'h000, 1'b1, F_APAR, F_VAL|F_APAR|code_f(11'h011)},
    '{4'b0000, 8'h00, 11'h000, 1'b1, F_APAR, F_VAL|code_f(11'h011)},
    '{4'b0010, 8'h00, 11'h000, 1'b0, 64'h0, F_VAL|code_f(11'h011)},
    '{4'b0010, 8'h00, 11'h000, 1'b0, 64'h0, F_VAL|F_APAR|code_f(11'h011)},
    '{4'b1000, 8'h81, 11'h000, 1'b0, 64'h0, F_VAL|F_APAR|F_UNC|syn_f(8'h81)|code_f(11'h011)},
    '{4'b0100, 8'h42, 11'h000, 1'b1, F_UNC, F_VAL|F_APAR|F_CORR|syn_f(8'h42)|code_f(11'h011)},
    '{4'b0001, 8'h00, 11'h7FF, 1'b1, F_IERR|F_VAL, F_VAL|F_APAR|F_CORR|F_IERR|syn_f(8'h42)|code_f(11'h7FF)},
    '{4'b0000, 8'h00, 11'h000, 1'b1, M_SYN, F_VAL|F_APAR|F_CORR|F_IERR|code_f(11'h7FF)},
    '{4'b1000, 8'h99, 11'h000, 1'b0, 64'h0, F_VAL|F_APAR|F_CORR|F_IERR|F_UNC|syn_f(8'h99)|code_f(11'h7FF)},
    '{4'b0000, 8'h00, 11'h000, 1'b1, M_SYN, F_VAL|F_APAR|F_CORR|F_IERR|F_UNC|syn_f(8'h99)|code_f(11'h7FF)},
    '{4'b0000, 8'h00, 11'h000, 1'b1, M_RSV, F_VAL|F_APAR|F_CORR|F_IERR|F_UNC|syn_f(8'h99)|code_f(11'h7FF)}
  };

  function automatic string req_of(input int idx);
    case (idx)
      0:  return "R2 R9 R10";
      1:  return "R3 R9";
      2:  return "R3";
      3:  return "R5 R6";
      4:  return "R5 R6";
      5:  return "R6";
      6:  return "R12";
      7:  return "R3 R9";
      8:  return "R8";
      9:  return "R4";
      10: return "R4";
      11: return "R4";
      12: return "R6";
      13: return "R7";
      14: return "R8 R9";
      15: return "R12";
      16: return "R6";
      17: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset state", status, 64'h0);
    for (int i = 0; i < NV; i++) begin
      {ecc_unc_evt, ecc_corr_evt, apar_fail_evt, int_err_evt} = VECS[i].ev;
      ecc_syn = VECS[i].syn;
      {code_pp, code_t, code_rrrr, code_ii, code_ll} = VECS[i].code;
      clr_en   = VECS[i].clr;
      clr_mask = VECS[i].mask;
      @(negedge clk);
      check(req_of(i), status, VECS[i].exp);
    end
    {ecc_unc_evt, ecc_corr_evt, apar_fail_evt, int_err_evt} = 4'b0000;
    clr_en = 1'b0;
    clr_mask = '0;
    @(negedge clk);
    check("R11 idle hold", status, VECS[NV-1].exp);
    // R1: reset in the middle of a run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 mid-run reset", status, 64'h0);
    // R5: corrected event alone sets only bit 46 plus valid and code
    ecc_corr_evt = 1'b1;
    ecc_syn = 8'hA5;
    {code_pp, code_t, code_rrrr, code_ii, code_ll} = 11'h2B4;
    @(negedge clk);
    ecc_corr_evt = 1'b0;
    check("R5 corrected only", status, F_CORR|F_VAL|syn_f(8'hA5)|code_f(11'h2B4));
    finish_run();
  end
endmodule